// File: doc/BRIEF.md
# Prime-Modulo Interleaved Bank Mapper

This block sits in front of a set of small on-chip banks and spreads word addresses across them. In its default mode the bank count is a prime of the form 2^k−1. The in-bank offset is the low bits of the address, which is the address modulo the words-per-bank count, and not the address divided by the bank count. The two counts are coprime, so every legal address lands on its own (bank, offset) pair. Power-of-two strides also rotate across all banks instead of piling onto one. A parameter selects plain low-bit interleaving instead, with 2^k banks.

Each accepted request enables exactly one bank and presents the offset on that bank's lane. A read returns the stored word on the response port one cycle later. A bank that was just accessed stays busy for a configurable number of cycles. A new request aimed at a busy bank waits with ready low. A request to an idle bank can issue in the very next cycle. Addresses beyond the mapped space are accepted at once and answered with an error. They touch no bank.

Top module: `prime_bank_mapper`

## Requirements
- R1: While reset is held and just after it, rsp_valid is 0, no bank enable is high, and req_ready is 1.
- R2: In prime mode, the bank index is the address modulo 2^BANK_K−1. With BANK_K=2, addresses 1, 8 and 16 select banks 1, 2 and 1, and address 21 selects bank 0.
- R3: In prime mode, the offset is the address modulo 2^OFF_W. It appears on lane `bank_off[b*OFF_W +: OFF_W]` of the enabled bank b. For example, addresses 8 and 16 give offset 0 and address 23 gives offset 7.
- R4: Every address from 0 to NBANK·2^OFF_W−1 maps to a distinct (bank, offset) pair. Data written to each address reads back unchanged.
- R5: At most one bit of bank_en is high. A bit is high only in a cycle where req_valid and req_ready are both 1.
- R6: Each accepted request produces exactly one response in the following cycle. A read response carries the last data written to that address.
- R7: After a bank is accessed at a clock edge, req_ready stays 0 for the next BUSY_CYC cycles when the request targets that bank.
- R8: Requests to different idle banks issue on consecutive cycles without stalling. A stride-8 sequence 0, 8, 16 visits three different banks.
- R9: An address at or above NBANK·2^OFF_W is accepted immediately, even when its low bits resemble a busy bank. It raises rsp_err, enables no bank, and leaves all stored data unchanged.
- R10: In sequential mode, the bank index is the low BANK_K address bits and the offset is the next OFF_W bits.
- R11: A write response has rsp_err 0 and rsp_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| bank_en | output | NBANK | One-hot bank enable for the accepted request |
| bank_off | output | NBANK·OFF_W | Per-bank offset lanes, zero on idle lanes |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Address was out of range |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and errors |

## Verification
The main build uses prime mode with BANK_K=2, OFF_W=3, ADDR_W=6 and BUSY_CYC=2. This gives three banks of eight words and a 24-word space. The addresses from 24 to 63 exercise the error path. The two-cycle busy window exercises both stalls and back-to-back issue. A second instance uses sequential mode with BANK_K=2 and BUSY_CYC=0, which accepts every cycle, so its low-bit bank and offset split can be swept directly.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

   typedef enum logic {
      MAP_PRIME = 1'b0,
      MAP_SEQ   = 1'b1
   } map_kind_e;

   typedef struct packed {
      logic vld;
      logic err;
      logic rd;
   } rsp_flags_t;

   function automatic int bank_count(map_kind_e kind, int k);
      return (kind == MAP_PRIME) ? ((1 << k) - 1) : (1 << k);
   endfunction

   function automatic bit is_prime(int p);
      if (p < 2) return 1'b0;
      for (int i = 2; i * i <= p; i++)
         if (p % i == 0) return 1'b0;
      return 1'b1;
   endfunction

endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
   import bmap_pkg::*;
#(
   parameter map_kind_e MAP_KIND = MAP_PRIME,
   parameter int        ADDR_W   = 6,
   parameter int        K        = 2,
   parameter int        OFF_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [K-1:0]      bank,
   output logic [OFF_W-1:0]  off,
   output logic              in_range
);
   localparam int NBANK = bank_count(MAP_KIND, K);
   localparam int WB    = 1 << OFF_W;
   localparam int CAP   = NBANK * WB;

   assign in_range = (int'(addr) < CAP);

   generate
      if (MAP_KIND == MAP_PRIME) begin : g_prime
         localparam int NDIG  = (ADDR_W + K - 1) / K;
         localparam int PAD_W = NDIG * K;
         localparam int FOLDS = ADDR_W;

         logic [PAD_W-1:0] acc;
         logic [PAD_W-1:0] part;

         // residue mod 2^K-1: add the K-bit digits until one digit is left
         always_comb begin
            acc  = PAD_W'(addr);
            part = '0;
            for (int f = 0; f < FOLDS; f++) begin
               part = '0;
               for (int d = 0; d < NDIG; d++)
                  part = part + PAD_W'(acc[d*K +: K]);
               acc = part;
            end
            if (acc == PAD_W'(NBANK)) bank = '0;
            else                      bank = acc[K-1:0];
         end

         assign off = addr[OFF_W-1:0];
      end else begin : g_seq
         assign bank = addr[K-1:0];
         assign off  = addr[K +: OFF_W];
      end
   endgenerate

endmodule

// File: rtl/bmap_bank.sv
module bmap_bank #(
   parameter int OFF_W    = 3,
   parameter int DATA_W   = 16,
   parameter int BUSY_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy
);
   localparam int WB = 1 << OFF_W;

   logic [DATA_W-1:0] mem [WB];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[off] <= wdata;
         else    rdata_q  <= mem[off];
      end
   end

   assign rdata = rdata_q;

   generate
      if (BUSY_CYC > 0) begin : g_busy
         localparam int CW = $clog2(BUSY_CYC + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (en)         cnt <= CW'(BUSY_CYC);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end

         assign busy = (cnt != '0);
      end else begin : g_free
         assign busy = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
   import bmap_pkg::*;
#(
   parameter map_kind_e MAP_KIND = MAP_PRIME,
   parameter int        BANK_K   = 2,
   parameter int        OFF_W    = 3,
   parameter int        ADDR_W   = 6,
   parameter int        DATA_W   = 16,
   parameter int        BUSY_CYC = 2,
   localparam int       NBANK    = bank_count(MAP_KIND, BANK_K),
   localparam int       WB       = 1 << OFF_W,
   localparam int       CAP      = NBANK * WB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic [NBANK-1:0]        bank_en,
   output logic [NBANK*OFF_W-1:0]  bank_off,
   output logic                    rsp_valid,
   output logic                    rsp_err,
   output logic [DATA_W-1:0]       rsp_rdata
);

   // elaboration-time parameter checks
   generate
      if (BANK_K < 2 || BANK_K > 8) begin : g_bad_k
         $error("BANK_K out of supported range");
      end
      if (MAP_KIND == MAP_PRIME && !is_prime((1 << BANK_K) - 1)) begin : g_bad_prime
         $error("2^BANK_K-1 must be prime in prime mode");
      end
      if (ADDR_W < BANK_K + OFF_W) begin : g_bad_aw
         $error("ADDR_W too narrow for the mapped space");
      end
      if (BUSY_CYC < 0) begin : g_bad_busy
         $error("BUSY_CYC must not be negative");
      end
   endgenerate

   logic [BANK_K-1:0] bank_sel;
   logic [OFF_W-1:0]  off_sel;
   logic              in_range;

   bmap_decode #(
      .MAP_KIND (MAP_KIND),
      .ADDR_W   (ADDR_W),
      .K        (BANK_K),
      .OFF_W    (OFF_W)
   ) u_dec (
      .addr     (req_addr),
      .bank     (bank_sel),
      .off      (off_sel),
      .in_range (in_range)
   );

   logic [NBANK-1:0]  busy_v;
   logic [DATA_W-1:0] rd_arr [NBANK];
   logic              tgt_busy;
   logic              accept;

   always_comb begin
      tgt_busy = 1'b0;
      for (int b = 0; b < NBANK; b++)
         if (in_range && bank_sel == BANK_K'(b)) tgt_busy = busy_v[b];
   end

   assign req_ready = !tgt_busy;
   assign accept    = req_valid && req_ready;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_lane
         assign bank_en[b] = accept && in_range && (bank_sel == BANK_K'(b));
         assign bank_off[b*OFF_W +: OFF_W] = bank_en[b] ? off_sel : '0;

         bmap_bank #(
            .OFF_W    (OFF_W),
            .DATA_W   (DATA_W),
            .BUSY_CYC (BUSY_CYC)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .we    (req_write),
            .off   (off_sel),
            .wdata (req_wdata),
            .rdata (rd_arr[b]),
            .busy  (busy_v[b])
         );
      end
   endgenerate

   rsp_flags_t        rsp_q;
   logic [BANK_K-1:0] rsp_bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q      <= '0;
         rsp_bank_q <= '0;
      end else begin
         rsp_q.vld  <= accept;
         rsp_q.err  <= accept && !in_range;
         rsp_q.rd   <= accept && in_range && !req_write;
         rsp_bank_q <= bank_sel;
      end
   end

   assign rsp_valid = rsp_q.vld;
   assign rsp_err   = rsp_q.err;

   always_comb begin
      rsp_rdata = '0;
      for (int b = 0; b < NBANK; b++)
         if (rsp_q.rd && rsp_bank_q == BANK_K'(b)) rsp_rdata = rd_arr[b];
   end

endmodule

// File: rtl/prime_bank_mapper_chk.sv
module prime_bank_mapper_chk #(
   parameter int NBANK    = 3,
   parameter int ADDR_W   = 6,
   parameter int CAP      = 24,
   parameter int BUSY_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [NBANK-1:0]  bank_en,
   input logic              rsp_valid,
   input logic              rsp_err
);
   logic acc;
   logic oor;
   assign acc = req_valid && req_ready;
   assign oor = (int'(req_addr) >= CAP);

   assert_en_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en));

   assert_en_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en != '0) |-> acc);

   assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !rsp_valid);

   assert_oor_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && oor) |=> rsp_err);

   assert_inrange_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !oor) |=> !rsp_err);

   assert_oor_no_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oor |-> (bank_en == '0));

   assert_oor_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && oor) |-> req_ready);

   generate
      if (BUSY_CYC > 0) begin : g_rest
         for (genvar b = 0; b < NBANK; b++) begin : g_b
            assert_bank_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
               bank_en[b] |=> !bank_en[b]);
         end
      end
   endgenerate

endmodule

bind prime_bank_mapper prime_bank_mapper_chk #(
   .NBANK    (NBANK),
   .ADDR_W   (ADDR_W),
   .CAP      (CAP),
   .BUSY_CYC (BUSY_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .bank_en   (bank_en),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err)
);

// File: tb/prime_bank_mapper_bench.sv
`timescale 1ns/1ps
module prime_bank_mapper_bench;
   import bmap_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // main instance: prime mode, 3 banks x 8 words, busy 2
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr  = '0;
   logic [15:0] req_wdata = '0;
   logic [2:0]  bank_en;
   logic [8:0]  bank_off;
   logic        rsp_valid;
   logic        rsp_err;
   logic [15:0] rsp_rdata;

   prime_bank_mapper #(
      .MAP_KIND (MAP_PRIME), .BANK_K (2), .OFF_W (3),
      .ADDR_W (6), .DATA_W (16), .BUSY_CYC (2)
   ) u_prime_bank_mapper (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .bank_en (bank_en), .bank_off (bank_off),
      .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata)
   );

   // second instance: sequential mode, 4 banks x 8 words, no busy time
   logic [5:0]  s_addr = '0;
   logic        s_ready;
   logic [3:0]  s_en;
   logic [11:0] s_off;
   logic        s_rvalid;
   logic        s_rerr;
   logic [15:0] s_rdata;

   prime_bank_mapper #(
      .MAP_KIND (MAP_SEQ), .BANK_K (2), .OFF_W (3),
      .ADDR_W (6), .DATA_W (16), .BUSY_CYC (0)
   ) u_prime_bank_mapper_seq (
      .clk (clk), .rst_n (rst_n),
      .req_valid (1'b1), .req_ready (s_ready), .req_write (1'b0),
      .req_addr (s_addr), .req_wdata (16'h0),
      .bank_en (s_en), .bank_off (s_off),
      .rsp_valid (s_rvalid), .rsp_err (s_rerr), .rsp_rdata (s_rdata)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct { bit wr; bit err; logic [15:0] data; } exp_t;
   exp_t        sb[$];
   logic [15:0] model [24];
   int          hits [3][8];
   bit          sweeping = 1'b0;
   bit          exp_next = 1'b0;

   task automatic issue(input bit wr, input int addr, input logic [15:0] data,
                        output int stalls);
      exp_t e;
      int   eb;
      int   eo;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = 6'(addr);
      req_wdata = data;
      stalls    = 0;
      #1;
      while (!req_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      e.wr  = wr;
      e.err = (addr >= 24);
      if (!e.err) begin
         eb = addr % 3;
         eo = addr % 8;
         chk(bank_en == 3'(1 << eb), "R2 bank select", int'(bank_en), 1 << eb);
         chk(bank_off[eb*3 +: 3] == 3'(eo), "R3 offset lane", int'(bank_off[eb*3 +: 3]), eo);
         for (int b = 0; b < 3; b++)
            if (bank_en[b] && sweeping) hits[b][int'(bank_off[b*3 +: 3])]++;
         e.data = wr ? 16'h0 : model[addr];
         if (wr) model[addr] = data;
      end else begin
         chk(bank_en == 3'b000, "R9 no enable", int'(bank_en), 0);
         e.data = 16'h0;
      end
      sb.push_back(e);
      exp_next = 1'b1;
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && (rsp_valid || exp_next)) begin
         chk(rsp_valid == exp_next, "R6 response timing", int'(rsp_valid), int'(exp_next));
         if (rsp_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R6 unexpected response", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(rsp_err == e.err, e.err ? "R9 error flag" : "R6 error flag",
                   int'(rsp_err), int'(e.err));
               chk(rsp_rdata == e.data, e.wr ? "R11 write rdata" : "R6 read data",
                   int'(rsp_rdata), int'(e.data));
            end
         end
      end
      exp_next = 1'b0;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int st;
      foreach (hits[b, o]) hits[b][o] = 0;
      foreach (model[a]) model[a] = 16'h0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", int'(rsp_valid), 0);
      chk(bank_en == 3'b000, "R1 bank_en in reset", int'(bank_en), 0);
      chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
      chk(bank_en == 3'b000, "R5 idle enables", int'(bank_en), 0);

      // R4: sweep every legal address, record (bank, offset) pairs
      sweeping = 1'b1;
      for (int a = 0; a < 24; a++) issue(1'b1, a, 16'(a * 7 + 100), st);
      sweeping = 1'b0;
      foreach (hits[b, o])
         chk(hits[b][o] == 1, "R4 pair hit once", hits[b][o], 1);
      for (int a = 0; a < 24; a++) issue(1'b0, a, 16'h0, st);
      idle(4);

      // R2/R3 named examples, read and written
      issue(1'b1, 1,  16'hA001, st);
      issue(1'b1, 8,  16'hA008, st);
      issue(1'b1, 16, 16'hA016, st);
      issue(1'b1, 21, 16'hA021, st);
      issue(1'b0, 23, 16'h0, st);
      issue(1'b0, 16, 16'h0, st);
      idle(4);

      // R7: same bank back to back stalls for BUSY_CYC cycles
      issue(1'b1, 0, 16'h1234, st);
      issue(1'b0, 3, 16'h0, st);
      chk(st == 2, "R7 stall count", st, 2);
      issue(1'b0, 0, 16'h0, st);
      chk(st == 2, "R7 stall count repeat", st, 2);
      idle(4);

      // R8: stride 8 and consecutive addresses hit idle banks
      issue(1'b0, 0, 16'h0, st);
      issue(1'b0, 8, 16'h0, st);
      chk(st == 0, "R8 stride no stall", st, 0);
      issue(1'b0, 16, 16'h0, st);
      chk(st == 0, "R8 stride no stall", st, 0);
      idle(4);
      issue(1'b1, 4, 16'h4444, st);
      issue(1'b1, 5, 16'h5555, st);
      chk(st == 0, "R8 next bank no stall", st, 0);

      // R9: out-of-range accepted at once, no effect on storage
      idle(4);
      issue(1'b1, 0, 16'h0F0F, st);
      issue(1'b1, 24, 16'hDEAD, st);
      chk(st == 0, "R9 immediate accept", st, 0);
      issue(1'b1, 30, 16'hBEEF, st);
      issue(1'b0, 63, 16'h0, st);
      idle(4);
      issue(1'b0, 6, 16'h0, st);
      issue(1'b0, 0, 16'h0, st);
      issue(1'b0, 7, 16'h0, st);
      idle(4);
      chk(sb.size() == 0, "R6 all responses seen", sb.size(), 0);

      // R10: sequential mode split
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         s_addr = 6'(a);
         #1;
         chk(s_ready == 1'b1, "R10 ready", int'(s_ready), 1);
         chk(s_en == 4'(1 << (a % 4)), "R10 bank select", int'(s_en), 1 << (a % 4));
         chk(s_off[(a % 4)*3 +: 3] == 3'(a / 4), "R10 offset", int'(s_off[(a % 4)*3 +: 3]), a / 4);
      end
      @(negedge clk);
      s_addr = 6'd40;
      #1;
      chk(s_en == 4'b0000, "R10 out of range", int'(s_en), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule